// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns one pair of quadrature signals from a shaft encoder into a signed position count. Both inputs arrive asynchronously, pass through a two-stage synchronizer, and are compared with the previously sampled pair. Every change of exactly one input moves the count by one step, so one full electrical cycle of the encoder yields four counts. The phase order of the two signals sets the direction, so swapping the two wires reverses the count.

By default the count is held as six BCD digits that wrap modulo 1,000,000. Values below zero therefore appear in ten's complement, so one step down from zero reads 999,999. A parameter replaces the BCD digits with a plain 24-bit binary counter that wraps modulo 2^24. A sample in which both inputs changed at once cannot be decoded. It leaves the count unchanged and sets a sticky rate-error flag. A synchronous clear zeroes both the count and the flag.

The `changing_o` output is high in every cycle after which the count or the error flag will change at the next clock edge. A snapshot circuit outside the block can delay its capture by that cycle. There is no streaming data path: all pins are plain level signals with no handshake.

Top module: `qdec_channel`

## Requirements
- R1: Every sampled change of exactly one input moves the count by one, so one complete input cycle of four states moves it by four.
- R2: With the state written {enc_a, enc_b}, the steps 00->01, 01->11, 11->10 and 10->00 count up, and the reverse steps count down. Exchanging the two inputs therefore reverses the direction.
- R3: In BCD mode (`BCD_MODE`=1) `count_o` holds six 4-bit digits, least significant digit in bits [3:0], and each digit stays in the range 0..9. A digit rolls from 9 to 0 with a carry going up, and from 0 to 9 with a borrow going down. The whole count wraps from 999,999 to 0 going up and from 0 to 999,999 going down.
- R4: In binary mode (`BCD_MODE`=0) `count_o` is a 24-bit binary count that wraps modulo 2^24. One step down from 0 reads 0xFFFFFF.
- R5: A sample in which both inputs changed leaves the count unchanged and sets `rate_err_o`. The flag stays set, while later legal steps keep counting, until a clear.
- R6: `clr` high at a clock edge zeroes the count and `rate_err_o` at that edge. This takes priority over a step or error decoded in the same cycle.
- R7: `changing_o` is high in exactly those cycles after which the count or the error flag is updated at the next edge. While it is low and `clr` is low, the count holds.
- R8: An input change set up before clock edge k raises `changing_o` after edge k+1 and appears on `count_o` after edge k+2. A state held for a single clock cycle is still counted.
- R9: After reset the count is 0 and `rate_err_o` and `changing_o` are 0. Input states are not decoded during the first three cycles after reset, while the synchronizer fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Quadrature input A, asynchronous |
| enc_b | input | 1 | Quadrature input B, asynchronous |
| clr | input | 1 | Synchronous clear of the count and the error flag |
| count_o | output | CNT_W (24) | Position count, BCD digits or binary |
| rate_err_o | output | 1 | Sticky flag for a double input change |
| changing_o | output | 1 | The count or the flag updates at the next edge |

## Verification
The bench goes after the wrap at zero in both directions. A design without a ten's-complement borrow chain would show 0xFFFFFF or a non-decimal digit instead of 999,999. It checks the ripple carry at 9 to 10, which a design with an unchained digit would miss, and double changes, where a wrong decoder would count a step or fail to latch the flag. It also checks the exact cycle in which `changing_o` and the new count appear, and a clear arriving in the same cycle as a step, where a design with the wrong priority would end at 1 instead of 0. A random walk on both counter variants then compares the count against a decimal and a binary model.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef logic [1:0] qstate_t;   // {a, b}

  typedef struct packed {
    logic up;
    logic dn;
    logic err;
  } qstep_t;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned WARM_CYCLES = 3;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= async_i;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  qstate_t prev_i,
  input  qstate_t cur_i,
  output qstep_t  step_o
);
  qstate_t flips;
  logic    single_flip;

  always_comb begin
    flips       = prev_i ^ cur_i;
    single_flip = flips[1] ^ flips[0];
    step_o.up   = enable && single_flip && (prev_i[1] ^ cur_i[0]);
    step_o.dn   = enable && single_flip && !(prev_i[1] ^ cur_i[0]);
    step_o.err  = enable && (&flips);
  end

  // R1: at most one of up, down or error per sample
  a_r1_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_o.up, step_o.dn, step_o.err}));

  // R5: a double change never produces a count step
  a_r5_double_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && prev_i == ~cur_i) |-> !(step_o.up || step_o.dn));
endmodule

// File: rtl/qdec_bcd_digit.sv
module qdec_bcd_digit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en_i,
  input  logic       up_i,
  output logic [3:0] digit_o,
  output logic       en_o
);
  logic [3:0] digit_q;
  logic [3:0] digit_d;
  logic       at_limit;

  always_comb begin
    at_limit = up_i ? (digit_q == 4'd9) : (digit_q == 4'd0);
    if (up_i) digit_d = at_limit ? 4'd0 : digit_q + 4'd1;
    else      digit_d = at_limit ? 4'd9 : digit_q - 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     digit_q <= '0;
    else if (clr)   digit_q <= '0;
    else if (en_i)  digit_q <= digit_d;
  end

  assign en_o    = en_i && at_limit;
  assign digit_o = digit_q;

  // R3: a digit never leaves the decimal range
  a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    digit_q <= 4'd9);
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter bit          BCD_MODE = 1'b1,
  parameter int unsigned DIGITS   = 6,
  parameter int unsigned BIN_W    = 24,
  localparam int unsigned CNT_W   = BCD_MODE ? 4*DIGITS : BIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step_en,
  input  logic             step_up,
  output logic [CNT_W-1:0] count_o
);
  generate
    if (BCD_MODE) begin : g_bcd
      logic [DIGITS:0] chain;
      assign chain[0] = step_en;
      for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        qdec_bcd_digit u_digit (
          .clk     (clk),
          .rst_n   (rst_n),
          .clr     (clr),
          .en_i    (chain[d]),
          .up_i    (step_up),
          .digit_o (count_o[4*d +: 4]),
          .en_o    (chain[d+1])
        );
      end
    end else begin : g_bin
      logic [CNT_W-1:0] bin_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bin_q <= '0;
        else if (clr)     bin_q <= '0;
        else if (step_en) bin_q <= step_up ? bin_q + 1'b1 : bin_q - 1'b1;
      end
      assign count_o = bin_q;

      // R4: a down step from zero gives the all-ones value
      a_r4_bin_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step_en && !step_up && bin_q == '0) |=> bin_q == '1);
    end
  endgenerate
endmodule

// File: rtl/qdec_channel.sv
module qdec_channel
  import qdec_pkg::*;
#(
  parameter bit          BCD_MODE = 1'b1,
  parameter int unsigned DIGITS   = 6,
  parameter int unsigned BIN_W    = 24,
  localparam int unsigned CNT_W   = BCD_MODE ? 4*DIGITS : BIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             clr,
  output logic [CNT_W-1:0] count_o,
  output logic             rate_err_o,
  output logic             changing_o
);
  localparam int unsigned WARM_W = $clog2(WARM_CYCLES + 1);

  qstate_t           cur_s;
  qstate_t           prev_q;
  qstep_t            step;
  logic [WARM_W-1:0] warm_q;
  logic              decode_en;
  logic              err_q;

  qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({enc_a, enc_b}),
    .sync_o  (cur_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      warm_q <= '0;
    end else begin
      prev_q <= cur_s;
      if (!decode_en) warm_q <= warm_q + 1'b1;
    end
  end

  assign decode_en = (warm_q == WARM_W'(WARM_CYCLES));

  qdec_decode u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (decode_en),
    .prev_i (prev_q),
    .cur_i  (cur_s),
    .step_o (step)
  );

  qdec_counter #(.BCD_MODE(BCD_MODE), .DIGITS(DIGITS), .BIN_W(BIN_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .step_en (step.up || step.dn),
    .step_up (step.up),
    .count_o (count_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (clr)      err_q <= 1'b0;
    else if (step.err) err_q <= 1'b1;
  end

  assign rate_err_o = err_q;
  assign changing_o = step.up || step.dn || (step.err && !err_q);

  // R6: clear empties count and flag at the edge
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_o == '0 && !rate_err_o));

  // R5: flag is sticky until a clear
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_err_o && !clr) |=> rate_err_o);

  // R5: an error sample leaves the count alone
  a_r5_err_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step.err && !clr) |=> $stable(count_o));

  // R7: a quiet cycle changes nothing
  a_r7_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!changing_o && !clr) |=> ($stable(count_o) && $stable(rate_err_o)));

  // R9: nothing is decoded while the synchronizer fills
  a_r9_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    !decode_en |-> !changing_o);
endmodule

// File: tb/qdec_channel_tb.sv
module qdec_channel_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, enc_a, enc_b, clr;
  logic [23:0] cnt_bcd, cnt_bin;
  logic err_bcd, err_bin, chg_bcd, chg_bin;

  qdec_channel u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .clr(clr),
    .count_o(cnt_bcd), .rate_err_o(err_bcd), .changing_o(chg_bcd));

  qdec_channel #(.BCD_MODE(1'b0)) u_dut_bin (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .clr(clr),
    .count_o(cnt_bin), .rate_err_o(err_bin), .changing_o(chg_bin));

  int          checks = 0;
  int          fails  = 0;
  int          exp_val = 0;
  logic [23:0] exp_bin = '0;
  bit          exp_err = 1'b0;
  logic [1:0]  cur_st = 2'b00;

  function automatic logic [23:0] to_bcd(input int v);
    logic [23:0] r;
    int          x;
    x = v;
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  // +1 up, -1 down, 0 none, 2 error
  function automatic int step_dir(input logic [1:0] p, input logic [1:0] n);
    case ({p, n})
      4'b0001, 4'b0111, 4'b1110, 4'b1000: return 1;
      4'b0100, 4'b1101, 4'b1011, 4'b0010: return -1;
      4'b0011, 4'b1100, 4'b0110, 4'b1001: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [1:0] neighbour(input logic [1:0] s, input bit up);
    case (s)
      2'b00: return up ? 2'b01 : 2'b10;
      2'b01: return up ? 2'b11 : 2'b00;
      2'b11: return up ? 2'b10 : 2'b01;
      default: return up ? 2'b00 : 2'b11;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic drive(input logic [1:0] s);
    int d;
    @(negedge clk);
    {enc_a, enc_b} = s;
    d = step_dir(cur_st, s);
    if (d == 2) exp_err = 1'b1;
    else begin
      exp_val = (exp_val + d + 1000000) % 1000000;
      exp_bin = exp_bin + 24'(d);
    end
    cur_st = s;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    check(cnt_bcd == to_bcd(exp_val), req, "bcd count", 32'(cnt_bcd), 32'(to_bcd(exp_val)));
    check(cnt_bin == exp_bin, req, "binary count", 32'(cnt_bin), 32'(exp_bin));
    check(err_bcd == exp_err && err_bin == exp_err, req, "rate error",
          {30'd0, err_bin, err_bcd}, {30'd0, exp_err, exp_err});
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    exp_val = 0; exp_bin = '0; exp_err = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0; clr = 1'b0;
    settle(3);
    // R9: reset state
    check(cnt_bcd == 0 && cnt_bin == 0, "R9", "count in reset", 32'(cnt_bcd), 0);
    rst_n = 1'b1;
    settle(10);
    check(!err_bcd && !chg_bcd && !err_bin && !chg_bin, "R9", "flags after reset",
          {28'd0, err_bcd, chg_bcd, err_bin, chg_bin}, 0);
    check_all("R9");

    // R8 and R7: exact latency of one up step
    drive(2'b01);
    @(negedge clk);
    check(chg_bcd == 1'b0, "R8", "changing after edge k", 32'(chg_bcd), 0);
    @(negedge clk);
    check(chg_bcd == 1'b1 && chg_bin == 1'b1, "R7", "changing after edge k+1",
          {30'd0, chg_bin, chg_bcd}, 3);
    check(cnt_bcd == 0, "R8", "count still old after edge k+1", 32'(cnt_bcd), 0);
    @(negedge clk);
    check(cnt_bcd == to_bcd(1) && chg_bcd == 1'b0, "R8", "count after edge k+2",
          32'(cnt_bcd), 32'(to_bcd(1)));

    // R1: one full cycle up gives four counts, each state held one cycle
    drive(2'b11); drive(2'b10); drive(2'b00); drive(2'b01);
    settle(4);
    check_all("R1");
    check(exp_val == 5, "R1", "model count", 32'(exp_val), 5);

    // R2: swapped order counts down
    drive(2'b00); drive(2'b10); drive(2'b11); drive(2'b01); drive(2'b00);
    settle(4);
    check_all("R2");

    // R3 and R4: down from zero, then back up
    do_clear();
    settle(4);
    check_all("R6");
    drive(2'b10);
    settle(4);
    check(cnt_bcd == 24'h999999, "R3", "wrap down", 32'(cnt_bcd), 32'h999999);
    check(cnt_bin == 24'hFFFFFF, "R4", "binary wrap down", 32'(cnt_bin), 32'hFFFFFF);
    drive(2'b00);
    settle(4);
    check_all("R3");

    // R3: ripple carry from digit 0 into digit 1
    for (int i = 0; i < 10; i++) drive(neighbour(cur_st, 1'b1));
    settle(4);
    check(cnt_bcd == 24'h000010, "R3", "carry 9 to 10", 32'(cnt_bcd), 32'h10);

    // R5: double change sets flag, count holds, later steps still count
    drive(~cur_st);
    settle(4);
    check_all("R5");
    drive(neighbour(cur_st, 1'b1));
    drive(neighbour(cur_st, 1'b1));
    settle(6);
    check_all("R5");
    check(err_bcd == 1'b1, "R5", "sticky flag", 32'(err_bcd), 1);

    // R6: clear beats a step decoded in the same cycle
    do_clear();
    settle(4);
    drive(neighbour(cur_st, 1'b1));
    @(negedge clk);
    @(negedge clk);
    check(chg_bcd == 1'b1, "R6", "step pending", 32'(chg_bcd), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    exp_val = 0; exp_bin = '0; exp_err = 1'b0;
    settle(4);
    check_all("R6");

    // Random walk across zero in both directions, holds of 1 to 3 cycles
    for (int n = 0; n < 3000; n++) begin
      drive(neighbour(cur_st, bit'($urandom_range(0, 1))));
      settle($urandom_range(0, 2));
      if (n % 100 == 99) begin
        settle(4);
        check_all("R1");
      end
    end
    settle(4);
    check_all("R2");
    finish_run();
  end
endmodule